// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes of an 8051-style multiplexed external bus. It runs on the oscillator clock and splits time into machine cycles. Each cycle has six states of two phases, so one cycle is twelve clocks. In every cycle it raises the address-latch pulse, drops the program-fetch strobe when code runs from external memory, and drops the data read or write strobe in cycles that access external data memory. A state/phase count is brought out so that neighbouring logic can line up with the same timing.

The CPU gives per-cycle intent flags: external code execution, external data access and its direction, MOVX/MOVC instruction, address-latch disable, idle and power-down. The block samples all of them once, at the clock edge that enters the first tick of a cycle, and holds them for the whole cycle. Every strobe comes straight from a flop, so the pins carry no decode glitches.

Ticks are numbered 0 to 11 within a cycle, where tick = 2*(state-1) + (phase-1). Outputs that change at a clock edge show the value for the tick being entered.

Top module: `ebs_bus_strobe_seq`

## Requirements
- R1: After reset the state/phase outputs read state 1, phase code 0. They advance one phase per clock, phase code 0 then 1, then on to the next state. After state 6 with phase code 1 they return to state 1, phase code 0.
- R2: When address-latch pulses are allowed, `ale_o` is high at ticks 1-2 and 7-8, which is two clocks twice per cycle. It is low at all other ticks.
- R3: In a cycle flagged as an external data access, the second address-latch pulse (ticks 7-8) is left out. The first pulse is kept.
- R4: In a cycle with external code execution and no external data access, `psen_n_o` is low at ticks 3-5 and 9-11. In every other normal cycle it stays high, so both fetch strobes are dropped during a data access.
- R5: In an external data access cycle, `rd_n_o` (direction flag 0) or `wr_n_o` (direction flag 1) is low at ticks 3-8, six clocks. The two are never low together, and neither is low while `psen_n_o` is low.
- R6: With the latch-disable flag set, `ale_o` stays high for the whole cycle unless the MOVX/MOVC flag is set or code runs from external memory. In either of those cases it pulses as in R2/R3.
- R7: All control inputs are sampled only at the edge that enters tick 0. A change at any other time has no effect until the next cycle.
- R8: In an idle cycle (power-down clear), `ale_o`, `psen_n_o`, `rd_n_o` and `wr_n_o` are all high for the whole cycle.
- R9: In a power-down cycle, `ale_o` and `psen_n_o` are low and `rd_n_o`/`wr_n_o` are high for the whole cycle. Power-down wins over idle.
- R10: While reset is held, `ale_o` is low and `psen_n_o`, `rd_n_o`, `wr_n_o` are high. The first cycle after reset runs with all control flags taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_code_i | input | 1 | Code is being fetched from external program memory |
| xdata_i | input | 1 | Coming cycle performs an external data access |
| xwrite_i | input | 1 | Direction of that access: 1 write, 0 read |
| movx_i | input | 1 | Current instruction is MOVX or MOVC |
| ale_off_i | input | 1 | Address-latch pulse disable control bit |
| idle_i | input | 1 | Idle mode request |
| pdown_i | input | 1 | Power-down mode request |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program store enable, active low |
| rd_n_o | output | 1 | External data read strobe, active low |
| wr_n_o | output | 1 | External data write strobe, active low |
| st_num_o | output | 3 | Current state, 1 to 6 |
| st_phase_o | output | 1 | Current phase, 0 for first, 1 for second |

## Verification
The bench builds the block with its default parameters: six states of two phases, two address-latch slots, two-clock latch pulses and a six-clock data strobe. With these settings a cycle is only twelve ticks and the control word is only seven bits. That makes it possible to run every one of the 128 flag combinations and compare all four strobes and the state count against arithmetic expectations at each of the twelve ticks. Halfway through each cycle the bench inverts every input, which tests at every remaining tick of every combination that only the boundary sample counts.

// File: rtl/ebs_pkg.sv
`timescale 1ns/1ps
package ebs_pkg;

  // Control word captured once per machine cycle.
  typedef struct packed {
    logic pdown;
    logic idle;
    logic ale_off;
    logic movx;
    logic xwrite;
    logic xdata;
    logic ext_code;
  } cyc_ctrl_t;

  // True when tick t lies in the window [start, start+len).
  function automatic logic in_win(input int t, input int start, input int len);
    return (t >= start) && (t < start + len);
  endfunction

  // Address-latch pulses are allowed unless disabled, and the disable
  // is overridden by external execution or a MOVX/MOVC instruction.
  function automatic logic ale_allowed(input cyc_ctrl_t c);
    return c.ext_code | c.movx | ~c.ale_off;
  endfunction

  // Linear tick index from zero-based state and phase.
  function automatic int tick_of(input int st, input int ph, input int phases);
    return st * phases + ph;
  endfunction

endpackage

// File: rtl/ebs_state_ctr.sv
`timescale 1ns/1ps
module ebs_state_ctr #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int ST_W   = $clog2(STATES),
  parameter int PH_W   = $clog2(PHASES),
  parameter int TICK_W = $clog2(STATES * PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ST_W-1:0]   state_q,
  output logic [PH_W-1:0]   phase_q,
  output logic [TICK_W-1:0] tick_nxt,
  output logic              wrap_nxt
);
  import ebs_pkg::*;

  localparam logic [ST_W-1:0] LAST_ST = ST_W'(STATES - 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [ST_W-1:0] state_nxt;
  logic [PH_W-1:0] phase_nxt;
  logic            last_ph;
  logic            last_st;

  assign last_ph = (phase_q == LAST_PH);
  assign last_st = (state_q == LAST_ST);

  always_comb begin
    if (last_ph) begin
      phase_nxt = '0;
      state_nxt = last_st ? '0 : state_q + ST_W'(1);
    end else begin
      phase_nxt = phase_q + PH_W'(1);
      state_nxt = state_q;
    end
  end

  assign wrap_nxt = last_ph && last_st;
  assign tick_nxt = TICK_W'(tick_of(int'(state_nxt), int'(phase_nxt), PHASES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      phase_q <= '0;
    end else begin
      state_q <= state_nxt;
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/ebs_ctrl_latch.sv
`timescale 1ns/1ps
module ebs_ctrl_latch (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_nxt,
  input  ebs_pkg::cyc_ctrl_t ctrl_in,
  output ebs_pkg::cyc_ctrl_t ctrl_q,
  output ebs_pkg::cyc_ctrl_t ctrl_nxt
);
  import ebs_pkg::*;

  // New flags take effect only on the edge entering tick 0.
  assign ctrl_nxt = wrap_nxt ? ctrl_in : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

endmodule

// File: rtl/ebs_strobe_gen.sv
`timescale 1ns/1ps
module ebs_strobe_gen #(
  parameter int TICKS     = 12,
  parameter int TICK_W    = $clog2(TICKS),
  parameter int SLOTS     = 2,
  parameter int ALE_LEAD  = 1,
  parameter int ALE_W     = 2,
  parameter int PSEN_LEAD = 3,
  parameter int RW_LEAD   = 3,
  parameter int RW_W      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TICK_W-1:0]  tick_nxt,
  input  ebs_pkg::cyc_ctrl_t ctrl_nxt,
  output logic               ale_q,
  output logic               psen_n_q,
  output logic               rd_n_q,
  output logic               wr_n_q
);
  import ebs_pkg::*;

  localparam int HALF   = TICKS / SLOTS;
  localparam int PSEN_W = HALF - PSEN_LEAD;

  int               t_i;
  logic [SLOTS-1:0] ale_hit;
  logic [SLOTS-1:0] psen_hit;
  logic             rw_hit;
  logic             ale_d;
  logic             psen_n_d;
  logic             rd_n_d;
  logic             wr_n_d;
  logic             run;

  assign t_i = int'(tick_nxt);

  // One address-latch and one fetch window per slot; a data access
  // keeps only the first latch pulse.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign ale_hit[k]  = in_win(t_i, k * HALF + ALE_LEAD, ALE_W) &&
                         ((k == 0) || !ctrl_nxt.xdata);
    assign psen_hit[k] = in_win(t_i, k * HALF + PSEN_LEAD, PSEN_W);
  end

  assign rw_hit = in_win(t_i, RW_LEAD, RW_W);
  assign run    = !ctrl_nxt.pdown && !ctrl_nxt.idle;

  always_comb begin
    if (ctrl_nxt.pdown) begin
      ale_d    = 1'b0;
      psen_n_d = 1'b0;
    end else if (ctrl_nxt.idle) begin
      ale_d    = 1'b1;
      psen_n_d = 1'b1;
    end else begin
      ale_d    = ale_allowed(ctrl_nxt) ? |ale_hit : 1'b1;
      psen_n_d = !(ctrl_nxt.ext_code && !ctrl_nxt.xdata && |psen_hit);
    end
  end

  assign rd_n_d = !(run && ctrl_nxt.xdata && !ctrl_nxt.xwrite && rw_hit);
  assign wr_n_d = !(run && ctrl_nxt.xdata &&  ctrl_nxt.xwrite && rw_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      psen_n_q <= 1'b1;
      rd_n_q   <= 1'b1;
      wr_n_q   <= 1'b1;
    end else begin
      ale_q    <= ale_d;
      psen_n_q <= psen_n_d;
      rd_n_q   <= rd_n_d;
      wr_n_q   <= wr_n_d;
    end
  end

endmodule

// File: rtl/ebs_bus_strobe_seq.sv
`timescale 1ns/1ps
module ebs_bus_strobe_seq #(
  parameter  int STATES    = 6,
  parameter  int PHASES    = 2,
  parameter  int ALE_LEAD  = 1,
  parameter  int ALE_W     = 2,
  parameter  int PSEN_LEAD = 3,
  parameter  int RW_LEAD   = 3,
  parameter  int RW_W      = 6,
  localparam int ST_OUT_W  = $clog2(STATES + 1),
  localparam int PH_W      = $clog2(PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_code_i,
  input  logic                xdata_i,
  input  logic                xwrite_i,
  input  logic                movx_i,
  input  logic                ale_off_i,
  input  logic                idle_i,
  input  logic                pdown_i,
  output logic                ale_o,
  output logic                psen_n_o,
  output logic                rd_n_o,
  output logic                wr_n_o,
  output logic [ST_OUT_W-1:0] st_num_o,
  output logic [PH_W-1:0]     st_phase_o
);
  import ebs_pkg::*;

  localparam int TICKS  = STATES * PHASES;
  localparam int TICK_W = $clog2(TICKS);
  localparam int ST_W   = $clog2(STATES);

  logic [ST_W-1:0]   state_q;
  logic [PH_W-1:0]   phase_q;
  logic [TICK_W-1:0] tick_nxt;
  logic              wrap_nxt;
  cyc_ctrl_t         ctrl_in;
  cyc_ctrl_t         ctrl_q;
  cyc_ctrl_t         ctrl_nxt;

  // Named views of the latched cycle flags, used by the checker.
  logic cyc_ext_w;
  logic cyc_idle_w;
  logic cyc_pdown_w;

  assign ctrl_in = '{pdown: pdown_i, idle: idle_i, ale_off: ale_off_i,
                     movx: movx_i, xwrite: xwrite_i, xdata: xdata_i,
                     ext_code: ext_code_i};

  ebs_state_ctr #(
    .STATES(STATES), .PHASES(PHASES),
    .ST_W(ST_W), .PH_W(PH_W), .TICK_W(TICK_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .state_q(state_q), .phase_q(phase_q),
    .tick_nxt(tick_nxt), .wrap_nxt(wrap_nxt)
  );

  ebs_ctrl_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wrap_nxt(wrap_nxt),
    .ctrl_in(ctrl_in), .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt)
  );

  ebs_strobe_gen #(
    .TICKS(TICKS), .TICK_W(TICK_W), .SLOTS(2),
    .ALE_LEAD(ALE_LEAD), .ALE_W(ALE_W), .PSEN_LEAD(PSEN_LEAD),
    .RW_LEAD(RW_LEAD), .RW_W(RW_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .tick_nxt(tick_nxt), .ctrl_nxt(ctrl_nxt),
    .ale_q(ale_o), .psen_n_q(psen_n_o),
    .rd_n_q(rd_n_o), .wr_n_q(wr_n_o)
  );

  assign st_num_o    = ST_OUT_W'(state_q) + ST_OUT_W'(1);
  assign st_phase_o  = phase_q;
  assign cyc_ext_w   = ctrl_q.ext_code;
  assign cyc_idle_w  = ctrl_q.idle;
  assign cyc_pdown_w = ctrl_q.pdown;

endmodule

// File: rtl/ebs_strobe_chk.sv
`timescale 1ns/1ps
module ebs_strobe_chk #(
  parameter int STATES   = 6,
  parameter int PHASES   = 2,
  parameter int RW_LEAD  = 3,
  parameter int ST_OUT_W = 3,
  parameter int PH_W     = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ale,
  input logic                psen_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic [ST_OUT_W-1:0] st_num,
  input logic [PH_W-1:0]     st_phase,
  input logic                ctrl_ext,
  input logic                ctrl_idle,
  input logic                ctrl_pdown
);
  localparam logic [ST_OUT_W-1:0] FIRST_ST = ST_OUT_W'(1);
  localparam logic [ST_OUT_W-1:0] LAST_ST  = ST_OUT_W'(STATES);
  localparam logic [PH_W-1:0]     LAST_PH  = PH_W'(PHASES - 1);
  localparam logic [ST_OUT_W-1:0] RW_ST    = ST_OUT_W'(RW_LEAD / PHASES + 1);
  localparam logic [PH_W-1:0]     RW_PH    = PH_W'(RW_LEAD % PHASES);

  assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_num == LAST_ST && st_phase == LAST_PH) |=> (st_num == FIRST_ST && st_phase == '0));

  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && !ctrl_idle) |=> ale);

  assert_psen_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_ext && !ctrl_pdown) |-> psen_n);

  assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_fetch_vs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!psen_n && (!rd_n || !wr_n)));

  assert_rd_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (st_num == RW_ST && st_phase == RW_PH));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_num == FIRST_ST && st_phase == '0) |-> ($stable(ctrl_idle) && $stable(ctrl_pdown) && $stable(ctrl_ext)));

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_idle && !ctrl_pdown) |-> (ale && psen_n && rd_n && wr_n));

  assert_pdown_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_pdown |-> (!ale && !psen_n && rd_n && wr_n));

endmodule

bind ebs_bus_strobe_seq ebs_strobe_chk #(
  .STATES(STATES), .PHASES(PHASES), .RW_LEAD(RW_LEAD),
  .ST_OUT_W(ST_OUT_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ale(ale_o), .psen_n(psen_n_o), .rd_n(rd_n_o), .wr_n(wr_n_o),
  .st_num(st_num_o), .st_phase(st_phase_o),
  .ctrl_ext(cyc_ext_w), .ctrl_idle(cyc_idle_w), .ctrl_pdown(cyc_pdown_w)
);

// File: tb/tb_ebs_bus_strobe_seq.sv
`timescale 1ns/1ps
module tb_ebs_bus_strobe_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_code_i = 1'b0, xdata_i = 1'b0, xwrite_i = 1'b0, movx_i = 1'b0;
  logic       ale_off_i = 1'b0, idle_i = 1'b0, pdown_i = 1'b0;
  logic       ale_o, psen_n_o, rd_n_o, wr_n_o;
  logic [2:0] st_num_o;
  logic [0:0] st_phase_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ebs_bus_strobe_seq dut (
    .clk(clk), .rst_n(rst_n),
    .ext_code_i(ext_code_i), .xdata_i(xdata_i), .xwrite_i(xwrite_i),
    .movx_i(movx_i), .ale_off_i(ale_off_i), .idle_i(idle_i), .pdown_i(pdown_i),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .st_num_o(st_num_o), .st_phase_o(st_phase_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [6:0] c);
    ext_code_i = c[0]; xdata_i = c[1]; xwrite_i = c[2]; movx_i = c[3];
    ale_off_i  = c[4]; idle_i  = c[5]; pdown_i  = c[6];
  endtask

  // Expected strobes from the requirements, for tick t of a cycle with flags c.
  task automatic expect_at(input logic [6:0] c, input int t,
                           output int e_ale, output int e_psen, output int e_rd,
                           output int e_wr, output string r_ale, output string r_psen,
                           output string r_rw);
    bit ext = c[0], xd = c[1], xw = c[2], mv = c[3], off = c[4], idl = c[5], pd = c[6];
    bit pulse_slot, fetch_slot, data_slot;
    pulse_slot = (t == 1 || t == 2) || (!xd && (t == 7 || t == 8));
    fetch_slot = (t >= 3 && t <= 5) || (t >= 9 && t <= 11);
    data_slot  = (t >= 3 && t <= 8);
    if (pd) begin
      e_ale = 0; e_psen = 0; e_rd = 1; e_wr = 1;
      r_ale = "R9"; r_psen = "R9"; r_rw = "R9";
    end else if (idl) begin
      e_ale = 1; e_psen = 1; e_rd = 1; e_wr = 1;
      r_ale = "R8"; r_psen = "R8"; r_rw = "R8";
    end else begin
      if (off && !mv && !ext) begin
        e_ale = 1; r_ale = "R6";
      end else begin
        e_ale = pulse_slot ? 1 : 0;
        r_ale = (xd && (t == 7 || t == 8)) ? "R3" : "R2";
      end
      e_psen = (ext && !xd && fetch_slot) ? 0 : 1;
      r_psen = "R4";
      e_rd   = (xd && !xw && data_slot) ? 0 : 1;
      e_wr   = (xd &&  xw && data_slot) ? 0 : 1;
      r_rw   = "R5";
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e_ale, e_psen, e_rd, e_wr;
    string r_ale, r_psen, r_rw, tag;
    drive(7'h7F);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs while reset is held
    chk("R10", "ale in reset", ale_o, 0);
    chk("R10", "psen_n in reset", psen_n_o, 1);
    chk("R10", "rd_n in reset", rd_n_o, 1);
    chk("R10", "wr_n in reset", wr_n_o, 1);
    chk("R1", "state in reset", st_num_o, 1);
    chk("R1", "phase in reset", st_phase_o, 0);
    rst_n = 1'b1;
    // R10: first cycle runs with all flags cleared, despite inputs at all-ones
    for (int t = 1; t < 12; t++) begin
      @(negedge clk);
      expect_at(7'h00, t, e_ale, e_psen, e_rd, e_wr, r_ale, r_psen, r_rw);
      chk("R10", "ale first cycle", ale_o, e_ale);
      chk("R10", "psen_n first cycle", psen_n_o, e_psen);
      chk("R10", "rd_n first cycle", rd_n_o, e_rd);
      chk("R1", "state first cycle", st_num_o, t / 2 + 1);
    end
    // Now at tick 11: sweep every flag combination.
    for (int c = 0; c < 128; c++) begin
      drive(7'(c));
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        expect_at(7'(c), t, e_ale, e_psen, e_rd, e_wr, r_ale, r_psen, r_rw);
        tag = (t > 5) ? "R7+" : "";
        chk({tag, r_ale},  $sformatf("ale c=%0d t=%0d", c, t), ale_o, e_ale);
        chk({tag, r_psen}, $sformatf("psen_n c=%0d t=%0d", c, t), psen_n_o, e_psen);
        chk({tag, r_rw},   $sformatf("rd_n c=%0d t=%0d", c, t), rd_n_o, e_rd);
        chk({tag, r_rw},   $sformatf("wr_n c=%0d t=%0d", c, t), wr_n_o, e_wr);
        chk("R1", $sformatf("state t=%0d", t), st_num_o, t / 2 + 1);
        chk("R1", $sformatf("phase t=%0d", t), st_phase_o, t % 2);
        // R7: flip every input mid-cycle; must not matter until next boundary
        if (t == 5) drive(~7'(c));
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule